// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches sixteen ordinary interrupt pins and one non-maskable pin. Every pin is first brought into the clock domain by a two-stage synchroniser. Each line can then pass through a three-sample majority-vote filter that removes short glitches. A per-line sense mode decides what counts as a condition: a rising edge, a falling edge, either edge, a high level or a low level. A detected condition sets a sticky flag. Software clears the flag by writing a one to it.

The ordinary flags are masked by a per-line enable. The results are ORed into a single shared interrupt request, and software reads the flag register to find the source. The enables have separate write-one-to-set and write-one-to-clear addresses, so single lines can be changed without a read-modify-write. Each time a flag goes from clear to set, the line also emits a one-cycle event pulse.

A global enable gates the ordinary lines. The non-maskable line has its own sense field, flag and output, and it ignores the global enable.

Top module: `xirq_lines`

## Requirements
- R1: Each ordinary line n has a 4-bit field at bits [4(n mod 8)+3 : 4(n mod 8)] of the register at address 6 + n/8. Bits [2:0] select the sense: 0 none, 1 rising, 2 falling, 3 both edges, 4 high level, 5 low level. Values 0, 6 and 7 never set a flag. Bit 3 enables the filter.
- R2: With the filter off, a flag reads set after the third rising clock edge that follows a pin change. With the filter on, it reads set after the fourth edge, provided the pin holds its new value.
- R3: Rising mode flags only low-to-high transitions, falling mode flags only high-to-low transitions, and both-edge mode flags either.
- R4: In an edge mode, a cleared flag stays clear while the pin holds steady. It sets again only on a new qualifying edge.
- R5: In a level mode, the flag sets while the pin matches the level. A clear write makes it read zero for exactly one cycle. If the pin still matches, the flag is set again at the next edge.
- R6: With the filter on, a pin pulse lasting one clock cycle sets no flag. A pulse lasting two or more cycles is accepted.
- R7: `lineEvent[n]` is high for exactly one cycle, in the same cycle that flag n goes from clear to set.
- R8: Address 4 sets enable bits and address 5 clears them; both are write-one and both read back the enable mask. `irq` is high when any flag is set and its enable bit is set.
- R9: Bit 0 at address 0 is the global enable. While it is zero, ordinary lines set no new flags and emit no events, and flags that are already set stay set.
- R10: Address 1 bits [2:0] hold the non-maskable sense, using the R1 encoding, and bit 3 enables its filter. Bit 0 at address 3 is the non-maskable flag; writing a one clears it. `nmiIrq` follows this flag regardless of the global enable, and a sense value of 0 keeps the flag clear.
- R11: After reset, every register reads zero, and `irq`, `nmiIrq` and `lineEvent` are low.
- R12: The flag register at address 2 clears only the bits written as one. Bits written as zero keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPins | input | NUM_LINES | Ordinary interrupt pins (asynchronous) |
| nmiPin | input | 1 | Non-maskable interrupt pin (asynchronous) |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Shared interrupt request of the ordinary lines |
| nmiIrq | output | 1 | Non-maskable interrupt request |
| lineEvent | output | NUM_LINES | One-cycle event pulse per line |

## Verification
A corrupted synchroniser stage, filter history or previous-sample register shows up at the ports as a flag that sets one edge early or late. It can also show up as a flag that sets on the wrong transition, or as a glitch that gets through. The bench therefore checks the exact edge on which each flag and event appears. A wrong flag or enable bit shows up on `rdData` at the next read and on `irq` in the same cycle. A wrong clear ordering in level mode is visible only in the single cycle after the clear write, so the bench reads the flag in that cycle and again one edge later.

// File: rtl/xirq_pkg.sv
`timescale 1ns/1ps
package xirq_pkg;
  localparam int DW     = 32;
  localparam int ADDR_W = 3;
  localparam int FLD_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_NMICFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 3'd2;
  localparam logic [ADDR_W-1:0] A_NMIFLAG = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENSET   = 3'd4;
  localparam logic [ADDR_W-1:0] A_ENCLR   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CFG     = 3'd6;

  typedef enum logic [2:0] {
    SNS_NONE = 3'd0,
    SNS_RISE = 3'd1,
    SNS_FALL = 3'd2,
    SNS_BOTH = 3'd3,
    SNS_HIGH = 3'd4,
    SNS_LOW  = 3'd5
  } senseT;

  typedef struct packed {
    logic flagClr;
    logic nmiClr;
  } strobeT;
endpackage

// File: rtl/xirq_line.sv
`timescale 1ns/1ps
module xirq_line
  import xirq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pin,
  input  logic [2:0] sense,
  input  logic       filtEn,
  input  logic       allow,
  input  logic       clr,
  output logic       flag,
  output logic       evt
);
  logic syncA, syncB, histA, histB, prevSel;
  logic majority, sel, hit, isLevel, setNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      histA   <= 1'b0;
      histB   <= 1'b0;
      prevSel <= 1'b0;
    end else begin
      syncA   <= pin;
      syncB   <= syncA;
      histA   <= syncB;
      histB   <= histA;
      prevSel <= sel;
    end
  end

  assign majority = (syncB & histA) | (syncB & histB) | (histA & histB);
  assign sel      = filtEn ? majority : syncB;

  always_comb begin
    hit     = 1'b0;
    isLevel = 1'b0;
    case (sense)
      SNS_RISE: hit = sel & ~prevSel;
      SNS_FALL: hit = ~sel & prevSel;
      SNS_BOTH: hit = sel ^ prevSel;
      SNS_HIGH: begin hit = sel;  isLevel = 1'b1; end
      SNS_LOW:  begin hit = ~sel; isLevel = 1'b1; end
      default:  hit = 1'b0;
    endcase
  end

  // a level condition yields to a clear in the same cycle; an edge does not
  assign setNow = hit & allow & ~(isLevel & clr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
      evt  <= 1'b0;
    end else begin
      flag <= (flag & ~clr) | setNow;
      evt  <= setNow & ~flag;
    end
  end

  AST_LEVEL_CLR_GAP: assert property (@(posedge clk) disable iff (!rstN) (clr && isLevel) |=> !flag); // R5
  AST_EVT_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN) evt |-> flag); // R7
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rstN) evt |=> !evt); // R7
  AST_GATED_NO_EVT: assert property (@(posedge clk) disable iff (!rstN) !allow |=> !evt); // R9
endmodule

// File: rtl/xirq_datapath.sv
`timescale 1ns/1ps
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int CFG_BITS = NUM_LINES * FLD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] extPins,
  input  logic                 nmiPin,
  input  logic [CFG_BITS-1:0]  cfgFlat,
  input  logic [FLD_W-1:0]     nmiCfg,
  input  logic                 globalEn,
  input  logic [NUM_LINES-1:0] enMask,
  input  strobeT               strb,
  input  logic [NUM_LINES-1:0] clrMask,
  output logic [NUM_LINES-1:0] flags,
  output logic                 nmiFlag,
  output logic [NUM_LINES-1:0] lineEvent,
  output logic                 irq
);
  logic nmiEvt;
  logic nmiOff;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    xirq_line u_line (
      .clk    (clk),
      .rstN   (rstN),
      .pin    (extPins[i]),
      .sense  (cfgFlat[i*FLD_W +: 3]),
      .filtEn (cfgFlat[i*FLD_W + 3]),
      .allow  (globalEn),
      .clr    (strb.flagClr & clrMask[i]),
      .flag   (flags[i]),
      .evt    (lineEvent[i])
    );
  end

  xirq_line u_nmi (
    .clk    (clk),
    .rstN   (rstN),
    .pin    (nmiPin),
    .sense  (nmiCfg[2:0]),
    .filtEn (nmiCfg[3]),
    .allow  (1'b1),
    .clr    (strb.nmiClr),
    .flag   (nmiFlag),
    .evt    (nmiEvt)
  );

  assign irq    = |(flags & enMask);
  assign nmiOff = (nmiCfg[2:0] == SNS_NONE) || (nmiCfg[2:0] > SNS_LOW);

  AST_NMI_SENSE_OFF: assert property (@(posedge clk) disable iff (!rstN) (nmiOff && !nmiFlag) |=> !nmiFlag); // R10
  AST_NMI_EVT_FLAG: assert property (@(posedge clk) disable iff (!rstN) nmiEvt |-> nmiFlag); // R10
  AST_GLOBAL_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rstN) !globalEn |=> ((flags & ~$past(flags)) == '0)); // R9
endmodule

// File: rtl/xirq_control.sv
`timescale 1ns/1ps
module xirq_control
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int CFG_BITS = NUM_LINES * FLD_W,
  localparam int CFG_REGS = (CFG_BITS + DW - 1) / DW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DW-1:0]        wrData,
  input  logic [NUM_LINES-1:0] flags,
  input  logic                 nmiFlag,
  output logic [DW-1:0]        rdData,
  output logic [CFG_BITS-1:0]  cfgFlat,
  output logic [FLD_W-1:0]     nmiCfg,
  output logic                 globalEn,
  output logic [NUM_LINES-1:0] enMask,
  output strobeT               strb,
  output logic [NUM_LINES-1:0] clrMask
);
  logic [DW-1:0] cfgRegs [CFG_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      nmiCfg   <= '0;
      enMask   <= '0;
      for (int k = 0; k < CFG_REGS; k++) cfgRegs[k] <= '0;
    end else if (wrEn) begin
      if (addr == A_CTRL)   globalEn <= wrData[0];
      if (addr == A_NMICFG) nmiCfg   <= wrData[FLD_W-1:0];
      if (addr == A_ENSET)  enMask   <= enMask | wrData[NUM_LINES-1:0];
      if (addr == A_ENCLR)  enMask   <= enMask & ~wrData[NUM_LINES-1:0];
      for (int k = 0; k < CFG_REGS; k++)
        if (addr == A_CFG + ADDR_W'(k)) cfgRegs[k] <= wrData;
    end
  end

  for (genvar k = 0; k < CFG_REGS; k++) begin : g_cfg
    localparam int LO = k * DW;
    localparam int HI = (LO + DW > CFG_BITS) ? CFG_BITS : LO + DW;
    assign cfgFlat[HI-1:LO] = cfgRegs[k][HI-LO-1:0];
  end

  assign strb.flagClr = wrEn && (addr == A_FLAGS);
  assign strb.nmiClr  = wrEn && (addr == A_NMIFLAG) && wrData[0];
  assign clrMask      = wrData[NUM_LINES-1:0];

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL:           rdData = DW'(globalEn);
      A_NMICFG:         rdData = DW'(nmiCfg);
      A_FLAGS:          rdData = DW'(flags);
      A_NMIFLAG:        rdData = DW'(nmiFlag);
      A_ENSET, A_ENCLR: rdData = DW'(enMask);
      default: begin
        for (int k = 0; k < CFG_REGS; k++)
          if (addr == A_CFG + ADDR_W'(k)) rdData = cfgRegs[k];
      end
    endcase
  end

  AST_ENSET_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_ENSET) |=> ((enMask & $past(wrData[NUM_LINES-1:0])) == $past(wrData[NUM_LINES-1:0]))); // R8
  AST_ENCLR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_ENCLR) |=> ((enMask & $past(wrData[NUM_LINES-1:0])) == '0)); // R8
endmodule

// File: rtl/xirq_lines.sv
`timescale 1ns/1ps
module xirq_lines
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] extPins,
  input  logic                 nmiPin,
  input  logic                 wrEn,
  input  logic [2:0]           addr,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic                 irq,
  output logic                 nmiIrq,
  output logic [NUM_LINES-1:0] lineEvent
);
  localparam int CFG_BITS = NUM_LINES * FLD_W;

  logic [CFG_BITS-1:0]  cfgFlat;
  logic [FLD_W-1:0]     nmiCfg;
  logic                 globalEn;
  logic [NUM_LINES-1:0] enMask;
  logic [NUM_LINES-1:0] clrMask;
  logic [NUM_LINES-1:0] flags;
  logic                 nmiFlag;
  strobeT               strb;

  xirq_control #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .flags(flags), .nmiFlag(nmiFlag), .rdData(rdData), .cfgFlat(cfgFlat),
    .nmiCfg(nmiCfg), .globalEn(globalEn), .enMask(enMask), .strb(strb),
    .clrMask(clrMask)
  );

  xirq_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .extPins(extPins), .nmiPin(nmiPin),
    .cfgFlat(cfgFlat), .nmiCfg(nmiCfg), .globalEn(globalEn), .enMask(enMask),
    .strb(strb), .clrMask(clrMask), .flags(flags), .nmiFlag(nmiFlag),
    .lineEvent(lineEvent), .irq(irq)
  );

  assign nmiIrq = nmiFlag;
endmodule

// File: tb/sim_xirq_lines.sv
`timescale 1ns/1ps
module sim_xirq_lines;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] extPins = '0;
  logic        nmiPin = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq, nmiIrq;
  logic [15:0] lineEvent;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] shadow [16];

  xirq_lines u0 (
    .clk(clk), .rstN(rstN), .extPins(extPins), .nmiPin(nmiPin), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq), .nmiIrq(nmiIrq),
    .lineEvent(lineEvent)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic setCfg(int line, logic [2:0] sns, logic filt);
    logic [31:0] word;
    shadow[line] = {filt, sns};
    for (int j = 0; j < 8; j++) word[j*4 +: 4] = shadow[(line/8)*8 + j];
    wr(3'(6 + line/8), word);
  endtask

  function automatic logic [31:0] bitOf(int n);
    return 32'(1) << n;
  endfunction

  task automatic flagIs(string tag, int line, logic exp);
    logic [31:0] v;
    rd(3'd2, v);
    chk(tag, 32'(v[line]), 32'(exp));
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R11 register reset", v, 0);
    end
    chk("R11 irq reset", 32'(irq), 0);
    chk("R11 nmiIrq reset", 32'(nmiIrq), 0);
    chk("R11 events reset", 32'(lineEvent), 0);
  endtask

  task automatic testRise();
    setCfg(0, 3'd1, 1'b0);
    tick(2);
    extPins[0] = 1'b1;
    tick(2);
    flagIs("R2 not yet set at edge 2", 0, 1'b0);
    chk("R7 no event before flag", 32'(lineEvent[0]), 0);
    tick(1);
    flagIs("R3 rise sets flag at edge 3", 0, 1'b1);
    chk("R7 event with flag", 32'(lineEvent[0]), 1);
    tick(1);
    chk("R7 event single cycle", 32'(lineEvent[0]), 0);
    wr(3'd2, bitOf(0));
    flagIs("R4 cleared", 0, 1'b0);
    tick(5);
    flagIs("R4 steady pin stays clear", 0, 1'b0);
    extPins[0] = 1'b0;
    tick(4);
    flagIs("R3 fall ignored in rise mode", 0, 1'b0);
    extPins[0] = 1'b1;
    tick(3);
    flagIs("R4 new edge sets again", 0, 1'b1);
    wr(3'd2, bitOf(0));
    extPins[0] = 1'b0;
    tick(3);
  endtask

  task automatic testFallBoth();
    setCfg(1, 3'd2, 1'b0);
    extPins[1] = 1'b1;
    tick(4);
    flagIs("R3 rise ignored in fall mode", 1, 1'b0);
    extPins[1] = 1'b0;
    tick(3);
    flagIs("R3 fall sets flag", 1, 1'b1);
    wr(3'd2, bitOf(1));
    setCfg(2, 3'd3, 1'b0);
    extPins[2] = 1'b1;
    tick(3);
    flagIs("R3 both mode rise", 2, 1'b1);
    wr(3'd2, bitOf(2));
    extPins[2] = 1'b0;
    tick(3);
    flagIs("R3 both mode fall", 2, 1'b1);
    wr(3'd2, bitOf(2));
  endtask

  task automatic testNone();
    setCfg(6, 3'd0, 1'b0);
    setCfg(7, 3'd7, 1'b0);
    extPins[6] = 1'b1; extPins[7] = 1'b1;
    tick(4);
    extPins[6] = 1'b0; extPins[7] = 1'b0;
    tick(4);
    flagIs("R1 sense 0 never flags", 6, 1'b0);
    flagIs("R1 sense 7 never flags", 7, 1'b0);
  endtask

  task automatic testLevel();
    setCfg(3, 3'd4, 1'b0);
    extPins[3] = 1'b1;
    tick(2);
    flagIs("R5 high level not yet", 3, 1'b0);
    tick(1);
    flagIs("R5 high level sets", 3, 1'b1);
    wr(3'd2, bitOf(3));
    flagIs("R5 one-cycle gap after clear", 3, 1'b0);
    tick(1);
    flagIs("R5 re-set while level holds", 3, 1'b1);
    extPins[3] = 1'b0;
    tick(3);
    wr(3'd2, bitOf(3));
    tick(2);
    flagIs("R5 stays clear once level gone", 3, 1'b0);
    setCfg(4, 3'd5, 1'b0);
    tick(1);
    flagIs("R5 low level sets", 4, 1'b1);
    extPins[4] = 1'b1;
    tick(3);
    wr(3'd2, bitOf(4));
    tick(2);
    flagIs("R5 low level cleared when pin high", 4, 1'b0);
    extPins[4] = 1'b0;
    setCfg(4, 3'd0, 1'b0);
    wr(3'd2, bitOf(4));
  endtask

  task automatic testFilter();
    setCfg(9, 3'd1, 1'b1);
    tick(3);
    extPins[9] = 1'b1;
    tick(1);
    extPins[9] = 1'b0;
    tick(6);
    flagIs("R6 one-cycle glitch rejected", 9, 1'b0);
    extPins[9] = 1'b1;
    tick(3);
    flagIs("R2 filtered not at edge 3", 9, 1'b0);
    tick(1);
    flagIs("R2 R6 filtered set at edge 4", 9, 1'b1);
    wr(3'd2, bitOf(9));
    extPins[9] = 1'b0;
    tick(4);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    setCfg(5, 3'd1, 1'b0);
    extPins[5] = 1'b1;
    tick(3);
    flagIs("R8 flag set", 5, 1'b1);
    chk("R8 irq masked while disabled", 32'(irq), 0);
    wr(3'd4, bitOf(5));
    chk("R8 irq after enable set", 32'(irq), 1);
    rd(3'd4, v); chk("R8 enable readback at set", v, bitOf(5));
    rd(3'd5, v); chk("R8 enable readback at clear", v, bitOf(5));
    wr(3'd2, 32'd0);
    flagIs("R12 zero write keeps flag", 5, 1'b1);
    wr(3'd5, bitOf(5));
    chk("R8 irq low after enable clear", 32'(irq), 0);
    wr(3'd4, bitOf(5));
    wr(3'd2, bitOf(5));
    chk("R8 irq low after flag clear", 32'(irq), 0);
    extPins[5] = 1'b1;
    wr(3'd5, bitOf(5));
  endtask

  task automatic testGlobalOff();
    logic [31:0] v;
    extPins[5] = 1'b0;
    tick(3);
    extPins[5] = 1'b1;
    tick(3);
    flagIs("R9 preset flag", 5, 1'b1);
    setCfg(10, 3'd1, 1'b0);
    wr(3'd0, 32'd0);
    extPins[10] = 1'b1;
    for (int c = 0; c < 6; c++) begin
      chk("R9 no event while off", 32'(lineEvent), 0);
      tick(1);
    end
    flagIs("R9 no new flag while off", 10, 1'b0);
    flagIs("R9 existing flag kept", 5, 1'b1);
    rd(3'd0, v); chk("R9 enable bit reads 0", v, 0);
    wr(3'd2, bitOf(5));
  endtask

  task automatic testNmi();
    wr(3'd1, 32'd1);
    nmiPin = 1'b1;
    tick(3);
    chk("R10 nmi sets with global off", 32'(nmiIrq), 1);
    wr(3'd3, 32'd1);
    chk("R10 nmi cleared", 32'(nmiIrq), 0);
    nmiPin = 1'b0;
    wr(3'd1, 32'd0);
    tick(2);
    nmiPin = 1'b1;
    tick(4);
    chk("R10 sense 0 disables nmi", 32'(nmiIrq), 0);
    wr(3'd1, 32'd4);
    tick(1);
    chk("R10 nmi high level", 32'(nmiIrq), 1);
    wr(3'd3, 32'd1);
    chk("R10 nmi level clear gap", 32'(nmiIrq), 0);
    tick(1);
    chk("R10 nmi level re-set", 32'(nmiIrq), 1);
    nmiPin = 1'b0;
    wr(3'd1, 32'd0);
    wr(3'd3, 32'd1);
    chk("R10 nmi final clear", 32'(nmiIrq), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    tick(3);
    #1 testReset();
    rstN = 1'b1;
    tick(2);
    testReset();
    wr(3'd0, 32'd1);
    testRise();
    testFallBoth();
    testNone();
    testLevel();
    testFilter();
    testIrq();
    testGlobalOff();
    testNmi();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule